// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block emits one test bit per transmit clock. It works in one of two modes. In pseudorandom mode a feedback shift register produces a maximal-length style sequence. In repetitive mode a user word is sent over and over. A small byte-wide register port holds a 32-bit pattern word, a 5-bit length field and a 5-bit second-tap field. A load strobe copies the pattern word into the shift register. After that the register shifts on every clock.

The length field L picks the active stages 0..L, so a sequence is L+1 bits long (1 to 32). In pseudorandom mode the new stage-0 bit is the XOR of stage L and the stage named by the second-tap field. The word is then used as the seed and is normally all ones. In repetitive mode the active stages rotate, so the output is word bits L down to 0, over and over. The serial output is always the highest active stage, stage L.

Top module: `pg_top`

## Requirements
- R1: Addresses 0, 1, 2 and 3 hold word bits 31:24, 23:16, 15:8 and 7:0. Each can be written and read back at the same address.
- R2: Address 4 holds the length field L in bits 4:0. Write bits 7:5 are dropped, and those bits read back as zero.
- R3: Address 5 holds the second-tap index T in bits 4:0. Bits 7:5 are dropped on write and read back as zero.
- R4: A write to address 6 or 7 changes no register, and a read of address 6 or 7 returns zero.
- R5: At a clock edge with loadStb high, the shift register takes the word, with stages above L cleared. serOut then equals word bit L. While loadStb stays high, no shifting happens.
- R6: With modeRepeat=1, the outputs after a load are word bits L, L-1, ..., 0, and this repeats with period L+1.
- R7: With modeRepeat=1 and L=0, serOut holds word bit 0 on every clock.
- R8: With modeRepeat=0, each clock shifts stage i into stage i+1 and puts stage L XOR stage T into stage 0. serOut shows stage L.
- R9: With an all-ones seed, L=6 and T=5, the output has period 127 and each period holds 64 ones.
- R10: After reset every register reads zero and serOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| modeRepeat | input | 1 | 1 = repetitive word, 0 = pseudorandom |
| loadStb | input | 1 | Copy the word into the shift register at the next edge |
| serOut | output | 1 | Serial pattern bit (stage L) |

## Verification
The hardest condition to reach is whole-period behaviour in pseudorandom mode. It shows up only after the seed has been loaded and 127 clocks or more have passed with no register write. The stimulus loads an all-ones seed with L=6 and T=5, records 254 outputs, and checks the repeat and the count of ones. It also compares two other length and tap settings bit by bit against a model built from R8. A held load strobe checks that loading takes priority over shifting. The repetitive-mode vectors run one-stage, odd-length and full 32-bit lengths.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  // strobes the control hands to the datapath each clock
  typedef struct packed {
    logic load;     // copy pattern word into the stage register
    logic rotate;   // circular shift over active stages
    logic advance;  // feedback shift over active stages
  } pgStrobe_t;
endpackage

// File: rtl/pg_regs.sv
`timescale 1ns/1ps
module pg_regs #(
  parameter int WIDTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [WIDTH-1:0]           patWord,
  output logic [$clog2(WIDTH)-1:0]   lenField,
  output logic [$clog2(WIDTH)-1:0]   tapSel
);
  localparam int NUM_BYTES = WIDTH / DATA_W;
  localparam int LEN_W     = $clog2(WIDTH);
  localparam int LEN_ADDR  = NUM_BYTES;
  localparam int TAP_ADDR  = NUM_BYTES + 1;

  logic [DATA_W-1:0] byteQ [NUM_BYTES];
  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  tapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BYTES; b++) byteQ[b] <= '0;
      lenQ <= '0;
      tapQ <= '0;
    end else if (wrEn) begin
      for (int b = 0; b < NUM_BYTES; b++)
        if (addr == ADDR_W'(b)) byteQ[b] <= wrData;
      if (addr == ADDR_W'(LEN_ADDR)) lenQ <= wrData[LEN_W-1:0];
      if (addr == ADDR_W'(TAP_ADDR)) tapQ <= wrData[LEN_W-1:0];
    end
  end

  // lowest address carries the most significant byte
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_word
    assign patWord[WIDTH-1-g*DATA_W -: DATA_W] = byteQ[g];
  end

  assign lenField = lenQ;
  assign tapSel   = tapQ;

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (addr == ADDR_W'(b)) rdData = byteQ[b];
    if (addr == ADDR_W'(LEN_ADDR)) rdData = DATA_W'(lenQ);
    if (addr == ADDR_W'(TAP_ADDR)) rdData = DATA_W'(tapQ);
  end
endmodule

// File: rtl/pg_ctrl.sv
`timescale 1ns/1ps
module pg_ctrl (
  input  logic              loadStb,
  input  logic              modeRepeat,
  output pg_pkg::pgStrobe_t strb
);
  // load dominates; otherwise exactly one shift kind per clock
  always_comb begin
    strb = '0;
    if (loadStb)         strb.load    = 1'b1;
    else if (modeRepeat) strb.rotate  = 1'b1;
    else                 strb.advance = 1'b1;
  end
endmodule

// File: rtl/pg_datapath.sv
`timescale 1ns/1ps
module pg_datapath #(
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pg_pkg::pgStrobe_t        strb,
  input  logic [WIDTH-1:0]         patWord,
  input  logic [$clog2(WIDTH)-1:0] lenField,
  input  logic [$clog2(WIDTH)-1:0] tapSel,
  output logic [WIDTH-1:0]         stageQ,
  output logic                     serOut
);
  localparam int LEN_W = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(WIDTH - 1);

  logic [WIDTH-1:0] activeMask;
  logic [WIDTH-1:0] stageNext;
  logic             topBit;
  logic             tapBit;
  logic             inBit;

  assign activeMask = ONES >> (TOP_IDX - lenField);
  assign topBit     = stageQ[lenField];
  assign tapBit     = stageQ[tapSel];
  assign inBit      = strb.rotate ? topBit : (topBit ^ tapBit);

  always_comb begin
    stageNext = stageQ;
    if (strb.load)
      stageNext = patWord & activeMask;
    else if (strb.rotate || strb.advance)
      stageNext = {stageQ[WIDTH-2:0], inBit} & activeMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= stageNext;
  end

  assign serOut = topBit;
endmodule

// File: rtl/pg_top.sv
`timescale 1ns/1ps
module pg_top #(
  parameter int WIDTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              modeRepeat,
  input  logic              loadStb,
  output logic              serOut
);
  localparam int LEN_W = $clog2(WIDTH);

  logic [WIDTH-1:0]  patWord;
  logic [LEN_W-1:0]  lenField;
  logic [LEN_W-1:0]  tapSel;
  logic [WIDTH-1:0]  stageQ;
  pg_pkg::pgStrobe_t strb;

  pg_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .patWord(patWord),
    .lenField(lenField), .tapSel(tapSel)
  );

  pg_ctrl uCtrl (
    .loadStb(loadStb), .modeRepeat(modeRepeat), .strb(strb)
  );

  pg_datapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .patWord(patWord),
    .lenField(lenField), .tapSel(tapSel), .stageQ(stageQ), .serOut(serOut)
  );
endmodule

// File: rtl/pg_chk.sv
`timescale 1ns/1ps
module pg_chk #(
  parameter int WIDTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWrEn,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [DATA_W-1:0]        regRdData,
  input logic                     modeRepeat,
  input logic                     loadStb,
  input logic                     serOut,
  input logic [WIDTH-1:0]         patWord,
  input logic [$clog2(WIDTH)-1:0] lenField,
  input logic [WIDTH-1:0]         stageQ
);
  localparam int LEN_W    = $clog2(WIDTH);
  localparam int LEN_ADDR = WIDTH / DATA_W;
  localparam int TAP_ADDR = LEN_ADDR + 1;

  // R2
  len_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(LEN_ADDR)) |-> (regRdData[DATA_W-1:LEN_W] == '0));

  // R3
  tap_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(TAP_ADDR)) |-> (regRdData[DATA_W-1:LEN_W] == '0));

  // R4
  unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(TAP_ADDR)) |-> (regRdData == '0));

  // R5
  load_shows_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !regWrEn) |=> (serOut == $past(patWord[lenField])));

  // R6
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRepeat && !loadStb && !regWrEn && lenField != '0)
      |=> (serOut == $past(stageQ[lenField - 1'b1])));

  // R7
  single_stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRepeat && !loadStb && !regWrEn && lenField == '0) |=> $stable(serOut));

  // R8
  prbs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeRepeat && !loadStb && !regWrEn && lenField != '0)
      |=> (serOut == $past(stageQ[lenField - 1'b1])));
endmodule

bind pg_top pg_chk #(.WIDTH(WIDTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regRdData(regRdData), .modeRepeat(modeRepeat), .loadStb(loadStb),
  .serOut(serOut), .patWord(patWord), .lenField(lenField), .stageQ(stageQ)
);

// File: tb/sim_pg_top.sv
`timescale 1ns/1ps
module sim_pg_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       modeRepeat = 1'b0;
  logic       loadStb = 1'b0;
  logic       serOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pg_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .modeRepeat(modeRepeat),
    .loadStb(loadStb), .serOut(serOut)
  );

  // word, length field, first 16 output bits (first bit in bit 15)
  localparam logic [52:0] VECS [5] = '{
    {32'h0000_00A5, 5'd7,  16'hA5A5},
    {32'h0000_000C, 5'd3,  16'hCCCC},
    {32'h8000_0001, 5'd31, 16'h8000},
    {32'h0000_0001, 5'd0,  16'hFFFF},
    {32'h0000_0013, 5'd4,  16'h9CE7}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setWord(input logic [31:0] w);
    wr(3'd0, w[31:24]); wr(3'd1, w[23:16]); wr(3'd2, w[15:8]); wr(3'd3, w[7:0]);
  endtask

  task automatic pulseLoad();
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // R8 model: out = stage L; stage 0 <= stage L ^ stage T
  task automatic prbsCompare(input logic [4:0] len, input logic [4:0] tap, input int n);
    logic [31:0] m;
    int bad;
    m = 32'hFFFF_FFFF;
    bad = 0;
    setWord(32'hFFFF_FFFF); wr(3'd4, {3'b0, len}); wr(3'd5, {3'b0, tap});
    modeRepeat = 1'b0;
    pulseLoad();
    for (int i = 0; i < n; i++) begin
      if (serOut !== m[len]) bad++;
      m = {m[30:0], m[len] ^ m[tap]};
      @(negedge clk);
    end
    check("R8 prbs mismatches", bad, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] got;
    logic [253:0] seq;
    int ones, mis;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 serOut", serOut, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R10 reg reset", d, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1 byte order and readback
    setWord(32'h1122_3344);
    rd(3'd0, d); check("R1 addr0", d, 8'h11);
    rd(3'd1, d); check("R1 addr1", d, 8'h22);
    rd(3'd2, d); check("R1 addr2", d, 8'h33);
    rd(3'd3, d); check("R1 addr3", d, 8'h44);
    // R2 length field width
    wr(3'd4, 8'h9F); rd(3'd4, d); check("R2 length", d, 8'h1F);
    // R3 tap field width
    wr(3'd5, 8'hE5); rd(3'd5, d); check("R3 tap", d, 8'h05);
    // R4 unused addresses
    wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
    rd(3'd6, d); check("R4 addr6", d, 0);
    rd(3'd7, d); check("R4 addr7", d, 0);
    rd(3'd0, d); check("R4 addr0 intact", d, 8'h11);
    rd(3'd3, d); check("R4 addr3 intact", d, 8'h44);
    rd(3'd4, d); check("R4 len intact", d, 8'h1F);
    rd(3'd5, d); check("R4 tap intact", d, 8'h05);

    // R6 / R7 repetitive vectors
    foreach (VECS[v]) begin
      setWord(VECS[v][52:21]);
      wr(3'd4, {3'b0, VECS[v][20:16]});
      modeRepeat = 1'b1;
      pulseLoad();
      for (int i = 15; i >= 0; i--) begin
        got[i] = serOut;
        @(negedge clk);
      end
      if (VECS[v][20:16] == 5'd0) check("R7 single stage", got, VECS[v][15:0]);
      else                        check("R6 repeat word", got, VECS[v][15:0]);
    end

    // R5 held load blocks shifting, then shifting resumes
    setWord(32'h0000_0080); wr(3'd4, 8'd7); modeRepeat = 1'b1;
    loadStb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R5 held load", serOut, 1);
    end
    loadStb = 1'b0;
    @(negedge clk);
    check("R5 after release", serOut, 0);
    // R5 load clears stages above L
    setWord(32'hFFFF_FF00); wr(3'd4, 8'd8);
    pulseLoad();
    check("R5 load bit L", serOut, 1);
    wr(3'd4, 8'd7);
    check("R5 upper cleared", serOut, 0);

    // R8 bit-exact pseudorandom
    prbsCompare(5'd10, 5'd3, 60);
    prbsCompare(5'd31, 5'd27, 60);

    // R9 period 127
    setWord(32'hFFFF_FFFF); wr(3'd4, 8'd6); wr(3'd5, 8'd5);
    modeRepeat = 1'b0;
    pulseLoad();
    for (int i = 0; i < 254; i++) begin
      seq[i] = serOut;
      @(negedge clk);
    end
    ones = 0; mis = 0;
    for (int i = 0; i < 127; i++) begin
      ones += int'(seq[i]);
      if (seq[i] !== seq[i+127]) mis++;
    end
    check("R9 seed bits", seq[6:0], 7'h7F);
    check("R9 ones per period", ones, 64);
    check("R9 period repeat", mis, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule